// File: doc/BRIEF.md
# Cascaded Mux-Divide-Gate Clock Slice

This block produces the clock-enable stream for one peripheral. Four free-running source tick streams arrive as one-cycle strobes in the system clock domain. A 2-bit field picks one of them. The chosen stream then passes through two divide stages in series, and each stage has its own 3-bit code. A disable bit can gate the result. A clock-select bit can also replace the divided path with a reference tick. The output is a registered one-cycle strobe, `out_tick`, which downstream logic uses as a clock enable.

Software programs six 32-bit words through a single-cycle write port. Source, divider and bypass changes are held in a shadow copy. The shadow copy is reloaded only when an output period ends, so a period is never cut short or stretched into a runt. The disable bit bypasses the shadow copy and gates the next output cycle directly. Because divider changes wait for a period boundary, the power-up restore order does not matter: disable word first, then the three divider words, then the source word, then the clock-select word. Pulses stay off until the disable bit is cleared.

Top module: `periph_clk_slice`

## Requirements
- R1: After reset, `out_tick` is 0, the disable word is all ones, the source field is 0, the bypass bit is 0 and both divide codes are 1. Clearing only the disable bit then gives one pulse on every cycle of source 0.
- R2: A write takes effect when `wr_en` is 1 at a rising edge, with the byte offset on `wr_addr`. The word offsets are: 0x00 source select, 0x04/0x08/0x0C divider words, 0x10 clock select, 0x14 disable. The field positions are: source field bits [5:4] of 0x00; stage-A code bits [5:3] of 0x08; stage-B code bits [2:0] of 0x08; bypass bit 6 of 0x10; gate bit 6 of 0x14.
- R3: Source codes 0, 1, 2 and 3 select `src_tick[0]` (primary A), `src_tick[1]` (primary B), `src_tick[2]` (secondary A) and `src_tick[3]` (secondary B).
- R4: Codes 1 to 6 divide by their own value. One output period lasts stage-A code times stage-B code selected-source ticks. `out_tick` goes high for one cycle, one cycle after the tick that completes the period.
- R5: A code of 0 or 7 in either stage is invalid and keeps `out_tick` low. While the active setting is invalid, it is reloaded on every cycle, so a valid write starts a fresh period at once.
- R6: New source, divide or bypass settings take effect only at the end of the current output period. Counting then restarts from zero.
- R7: With gate bit 1, `out_tick` is 0 from the cycle after the write. The counters keep running. The other bits of the disable word have no effect.
- R8: With the bypass bit active, `out_tick` repeats `ref_tick` one cycle later, and the gate bit still applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | 4 | Source tick strobes, index = source code |
| ref_tick | input | 1 | Reference tick used in bypass |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte offset of the written word |
| wr_data | input | 32 | Write data |
| out_tick | output | 1 | Gated, divided output strobe |

## Verification
Results fall due at different times after each stimulus:
- A divided pulse shows on `out_tick` one cycle after the source tick that closes its period.
- A gate write shows on the cycle after the capturing edge.
- A divider or source write shows only after the running period has finished.

The bench model steps on the rising edge from the values captured before that edge, in the same way as the registers. Every comparison samples `out_tick` at the falling edge that follows. The window checks use periodic source patterns and start only after waiting longer than the longest possible old period. This makes each expected pulse count independent of phase. The boundary case under R6 has an expected count worked out to the exact cycle.

// File: rtl/pcs_pkg.sv
// Package for the peripheral clock slice.
// Holds the shared field widths, the register word indices, the live
// configuration record and the divide-code validity rule.
package pcs_pkg;

    localparam int NUM_SRC   = 4;
    localparam int SEL_W     = $clog2(NUM_SRC);
    localparam int CODE_W    = 3;
    localparam int CODE_MAX  = 6;
    localparam int NUM_WORDS = 6;

    localparam int WORD_SRC  = 0;
    localparam int WORD_DIV0 = 1;
    localparam int WORD_CSEL = 4;
    localparam int WORD_DIS  = 5;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [CODE_W-1:0] d1;
        logic [CODE_W-1:0] d2;
        logic              byp;
    } slice_cfg_t;

    localparam slice_cfg_t CFG_RESET = '{sel: '0, d1: CODE_W'(1), d2: CODE_W'(1), byp: 1'b0};

    // A divide code is usable only from 1 to CODE_MAX
    function automatic logic code_ok(input logic [CODE_W-1:0] c);
        return (c != '0) && (c <= CODE_W'(CODE_MAX));
    endfunction

endpackage

// File: rtl/pcs_regs.sv
// Register file of the clock slice.
// Six data words sit at 4-byte steps. Writes complete in one cycle.
// The module extracts the requested configuration and the gate bit.
// Assumes field positions given by parameters lie inside their word.
module pcs_regs
    import pcs_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 5,
    parameter int MUX_SHIFT   = 4,
    parameter int DIV_A_WORD  = 1,
    parameter int DIV_A_SHIFT = 3,
    parameter int DIV_B_WORD  = 1,
    parameter int DIV_B_SHIFT = 0,
    parameter int GATE_BIT    = 6,
    parameter int BYPASS_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output slice_cfg_t        cfg_req,
    output logic              gate_off
);

    localparam int IDX_W  = ADDR_W - 2;
    localparam int A_WORD = WORD_DIV0 + DIV_A_WORD;
    localparam int B_WORD = WORD_DIV0 + DIV_B_WORD;

    // Reset image: disable word all ones, both divide codes equal to 1
    function automatic logic [DATA_W-1:0] reset_word(input int w);
        logic [DATA_W-1:0] v;
        v = '0;
        if (w == WORD_DIS) v = '1;
        if (w == A_WORD)   v = v | (DATA_W'(1) << DIV_A_SHIFT);
        if (w == B_WORD)   v = v | (DATA_W'(1) << DIV_B_SHIFT);
        return v;
    endfunction

    logic [NUM_WORDS-1:0][DATA_W-1:0] word_q;
    logic [IDX_W-1:0]                 wr_idx;
    logic                             wr_hit;
    logic                             unused_word_bits;

    assign wr_idx = wr_addr[ADDR_W-1:2];
    assign wr_hit = wr_en && (wr_addr[1:0] == 2'b00) && (wr_idx < IDX_W'(NUM_WORDS));

    // Capture bus writes into the addressed word, load the reset image on reset
    always_ff @(posedge clk) begin
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (!rst_n) begin
                word_q[w] <= reset_word(w);
            end else if (wr_hit && (wr_idx == IDX_W'(w))) begin
                word_q[w] <= wr_data;
            end
        end
    end

    assign cfg_req.sel = word_q[WORD_SRC][MUX_SHIFT +: SEL_W];
    assign cfg_req.d1  = word_q[A_WORD][DIV_A_SHIFT +: CODE_W];
    assign cfg_req.d2  = word_q[B_WORD][DIV_B_SHIFT +: CODE_W];
    assign cfg_req.byp = word_q[WORD_CSEL][BYPASS_BIT];
    assign gate_off    = word_q[WORD_DIS][GATE_BIT];

    assign unused_word_bits = ^word_q;

    // Reset leaves every output gated
    assert_reset_gated_R1: assert property (@(posedge clk) !rst_n |=> gate_off)
        else $error("reset did not leave the gate closed");

    // Setting the gate bit closes the gate on the next cycle
    assert_disable_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && (wr_idx == IDX_W'(WORD_DIS)) && wr_data[GATE_BIT]) |=> gate_off)
        else $error("gate write not captured");

endmodule

// File: rtl/pcs_div_stage.sv
// One divide stage of the clock slice.
// Counts input ticks while run is high. On the tick that completes
// 'code' ticks it raises tick_out in the same cycle and wraps to zero.
// Assumes code is valid whenever run is high, and that code changes
// only in a cycle where clr is high.
module pcs_div_stage
    import pcs_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic          tick_in,
    input  logic [CW-1:0] code,
    output logic          tick_out
);

    logic [CW-1:0] cnt_q;
    logic          last;

    assign last     = (cnt_q == code - CW'(1));
    assign tick_out = run && tick_in && last;

    // Advance on each input tick, wrap after the last one, clear on reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && tick_in) begin
            cnt_q <= last ? '0 : cnt_q + CW'(1);
        end
    end

    // The count never reaches the code while the stage runs
    assert_count_below_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < code))
        else $error("divide count escaped its range");

endmodule

// File: rtl/pcs_shadow.sv
// Active-configuration shadow of the clock slice.
// Holds the source, divide and bypass setting that is in use. It
// reloads from the register file only at an output period boundary:
// a reference tick in bypass, a completed divided period, or any
// cycle in which the active divide codes are invalid.
module pcs_shadow
    import pcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  slice_cfg_t cfg_req,
    input  logic       ref_tick,
    input  logic       div_pulse,
    output slice_cfg_t cfg_act,
    output logic       cfg_ok,
    output logic       reload
);

    assign cfg_ok = code_ok(cfg_act.d1) && code_ok(cfg_act.d2);
    assign reload = cfg_act.byp ? ref_tick : (div_pulse || !cfg_ok);

    // Copy the requested setting at each period boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_act <= CFG_RESET;
        end else if (reload) begin
            cfg_act <= cfg_req;
        end
    end

    // Between boundaries the active setting does not move
    assert_cfg_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(cfg_act))
        else $error("active setting changed inside a period");

    // An invalid divided setting is replaced on the very next cycle
    assert_invalid_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ok && !cfg_act.byp) |=> (cfg_act == $past(cfg_req)))
        else $error("invalid setting not reloaded");

endmodule

// File: rtl/periph_clk_slice.sv
// Peripheral clock slice: source mux, two cascaded dividers, gate.
// All clocks are modelled as one-cycle tick strobes in the clk domain.
// The output is a registered strobe, so every pulse lasts exactly
// one cycle and gating can never shorten a pulse.
module periph_clk_slice
    import pcs_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 5,
    parameter int MUX_SHIFT   = 4,
    parameter int DIV_A_WORD  = 1,
    parameter int DIV_A_SHIFT = 3,
    parameter int DIV_B_WORD  = 1,
    parameter int DIV_B_SHIFT = 0,
    parameter int GATE_BIT    = 6,
    parameter int BYPASS_BIT  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               ref_tick,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               out_tick
);

    slice_cfg_t cfg_req;
    slice_cfg_t cfg_act;
    logic       gate_off;
    logic       cfg_ok;
    logic       reload;
    logic       run;
    logic       sel_tick;
    logic       tick_a;
    logic       div_pulse;

    pcs_regs #(
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .MUX_SHIFT   (MUX_SHIFT),
        .DIV_A_WORD  (DIV_A_WORD),
        .DIV_A_SHIFT (DIV_A_SHIFT),
        .DIV_B_WORD  (DIV_B_WORD),
        .DIV_B_SHIFT (DIV_B_SHIFT),
        .GATE_BIT    (GATE_BIT),
        .BYPASS_BIT  (BYPASS_BIT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cfg_req  (cfg_req),
        .gate_off (gate_off)
    );

    pcs_shadow u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_req   (cfg_req),
        .ref_tick  (ref_tick),
        .div_pulse (div_pulse),
        .cfg_act   (cfg_act),
        .cfg_ok    (cfg_ok),
        .reload    (reload)
    );

    assign sel_tick = src_tick[cfg_act.sel];
    assign run      = cfg_ok && !cfg_act.byp;

    pcs_div_stage u_stage_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (reload),
        .run      (run),
        .tick_in  (sel_tick),
        .code     (cfg_act.d1),
        .tick_out (tick_a)
    );

    pcs_div_stage u_stage_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (reload),
        .run      (run),
        .tick_in  (tick_a),
        .code     (cfg_act.d2),
        .tick_out (div_pulse)
    );

    // Register the gated strobe from either the divided path or the reference
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_tick <= 1'b0;
        end else begin
            out_tick <= !gate_off && (cfg_act.byp ? ref_tick : div_pulse);
        end
    end

    // A closed gate silences the next output cycle
    assert_gate_silences_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gate_off |=> !out_tick)
        else $error("pulse passed a closed gate");

    // An invalid divided setting produces no pulse
    assert_invalid_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ok && !cfg_act.byp) |=> !out_tick)
        else $error("pulse from invalid divide code");

    // In bypass the output repeats the reference one cycle later
    assert_bypass_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_act.byp && !gate_off) |=> (out_tick == $past(ref_tick)))
        else $error("bypass output does not follow reference");

endmodule

// File: tb/periph_clk_slice_tb.sv
`timescale 1ns/1ps
// Bench for the peripheral clock slice.
// It has two kinds of check:
// - A behavioural model uses a single product counter and is compared
//   with out_tick on every falling edge.
// - Windowed pulse counts check the expected rates.
module periph_clk_slice_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick = '0;
    logic        ref_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        out_tick;

    int    n_checks = 0;
    int    n_errors = 0;
    string tag = "R1";

    // model state
    logic [31:0] mw [0:5];
    int  a_sel, a_d1, a_d2, a_byp, m_cnt;
    bit  m_out = 1'b0;

    always #4 clk = ~clk;

    periph_clk_slice u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .ref_tick (ref_tick),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .out_tick (out_tick)
    );

    // Periodic sources: every 1, 2, 3, 5 cycles; reference every 4
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            ph++;
            src_tick[0] = 1'b1;
            src_tick[1] = (ph % 2 == 0);
            src_tick[2] = (ph % 3 == 0);
            src_tick[3] = (ph % 5 == 0);
            ref_tick    = (ph % 4 == 0);
        end
    end

    // Reference model, one step per rising edge
    initial begin
        bit valid, pulse, apply;
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                mw[0] = 32'h0; mw[1] = 32'h0; mw[2] = 32'h9;
                mw[3] = 32'h0; mw[4] = 32'h0; mw[5] = 32'hFFFF_FFFF;
                a_sel = 0; a_d1 = 1; a_d2 = 1; a_byp = 0; m_cnt = 0;
                m_out = 1'b0;
            end else begin
                valid = (a_d1 >= 1) && (a_d1 <= 6) && (a_d2 >= 1) && (a_d2 <= 6);
                pulse = 1'b0;
                if ((a_byp == 0) && valid && src_tick[a_sel]) begin
                    m_cnt++;
                    if (m_cnt == a_d1 * a_d2) begin
                        pulse = 1'b1;
                        m_cnt = 0;
                    end
                end
                m_out = !mw[5][6] && ((a_byp != 0) ? ref_tick : pulse);
                apply = (a_byp != 0) ? ref_tick : (pulse || !valid);
                if (apply) begin
                    a_sel = int'((mw[0] >> 4) & 32'h3);
                    a_d1  = int'((mw[2] >> 3) & 32'h7);
                    a_d2  = int'(mw[2] & 32'h7);
                    a_byp = int'(mw[4][6]);
                    m_cnt = 0;
                end
                if (wr_en && (wr_addr[1:0] == 2'b00) && (wr_addr[4:2] < 3'd6))
                    mw[wr_addr[4:2]] = wr_data;
            end
        end
    end

    // Cycle-by-cycle comparison against the model
    initial begin
        forever begin
            @(negedge clk);
            n_checks++;
            if (out_tick !== m_out) begin
                n_errors++;
                $display("FAIL %s model compare: out_tick actual=%b expected=%b", tag, out_tick, m_out);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s pulse count: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_window(input int n, input int exp, input string req);
        int c;
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (out_tick === 1'b1) c++;
        end
        chk(req, c, exp);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run state actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state and reset divide codes
        tag = "R1";
        idle(5);
        rst_n = 1'b1;
        count_window(20, 0, "R1");
        wr(5'h14, 32'h0);
        idle(2);
        count_window(20, 20, "R1");

        // R2 and R4: codes 2 and 3 in the word at 0x08, source 0
        tag = "R4";
        wr(5'h08, (32'd2 << 3) | 32'd3);
        idle(20);
        count_window(60, 10, "R2");
        wr(5'h08, (32'd6 << 3) | 32'd6);
        idle(80);
        count_window(72, 2, "R4");

        // R3: every source under codes 1 and 3
        tag = "R3";
        wr(5'h08, (32'd1 << 3) | 32'd3);
        wr(5'h00, 32'd1 << 4);
        idle(80);
        count_window(60, 10, "R3");
        wr(5'h00, 32'd2 << 4);
        idle(40);
        count_window(90, 10, "R3");
        wr(5'h00, 32'd3 << 4);
        idle(40);
        count_window(150, 10, "R3");

        // R5: codes 7 and 0 silence the output; a valid code restarts it
        tag = "R5";
        wr(5'h08, (32'd1 << 3) | 32'd7);
        idle(40);
        count_window(50, 0, "R5");
        wr(5'h08, 32'd2);
        idle(5);
        count_window(50, 0, "R5");
        wr(5'h08, (32'd1 << 3) | 32'd2);
        idle(20);
        count_window(100, 10, "R5");

        // R6: a change mid-period waits for the 36-tick period to finish
        tag = "R6";
        wr(5'h00, 32'h0);
        idle(20);
        wr(5'h08, 32'd7);
        idle(10);
        wr(5'h08, (32'd6 << 3) | 32'd6);
        wr(5'h08, (32'd1 << 3) | 32'd1);
        count_window(30, 0, "R6");
        count_window(20, 16, "R6");

        // R7: gate bit 6 of 0x14; the other bits are ignored
        tag = "R7";
        wr(5'h14, 32'd1 << 6);
        count_window(20, 0, "R7");
        wr(5'h14, 32'h0);
        count_window(10, 10, "R7");
        wr(5'h14, ~(32'd1 << 6));
        count_window(10, 10, "R7");

        // R8: bypass follows the reference; the gate still applies
        tag = "R8";
        wr(5'h14, 32'h0);
        wr(5'h10, 32'd1 << 6);
        idle(10);
        count_window(40, 10, "R8");
        wr(5'h14, 32'd1 << 6);
        count_window(20, 0, "R8");
        wr(5'h14, 32'h0);
        wr(5'h10, 32'h0);
        idle(20);
        count_window(20, 20, "R8");

        finish_run();
    end

endmodule